// File: doc/BRIEF.md
# Line Buffer Host Command and Mode Controller

This block is the system-bus side of a serial line buffer. A host processor or a DMA controller writes 16-bit words into it; each word is captured when the write strobe returns high. Depending on chip-select, command/data and DMA-acknowledge, a word either becomes a command or is stored as image data in a 320-word line memory. The memory itself lives outside this block, which drives its write port.

Commands carry an opcode in the top four bits. Each opcode is honoured only in certain operating states. The block holds the configuration registers: clocking and extension flags, DMA word count, preamble length and output format. It steps between an idle configuration state, a line-writing state, a sending state and a send-complete state. It keeps the write address and the stored word count, drives an active-low DMA request, and starts the serial send engine with a one-cycle pulse. A stop command returns it to idle without losing the configuration.

Top module: `line_cmd_ctrl`

## Requirements
- R1: After reset the mode output is 0 (static), `busy_n`, `intr_n` and `dreq_n` are high, `mem_we` and `send_start` are low, and every configuration output is zero (request clock, MSB-first, FIFO).
- R2: A word is taken only on a low-to-high transition of `wr_n`, with the result visible one clock after the clock that sees `wr_n` high. A write with both `cs_n` and `dack_n` high changes nothing.
- R3: A write with `cs_n` low, `cd` high and `dack_n` high is a command. A write with `cs_n` low and `cd` low, or with `dack_n` low, is a data word. A data word is stored (`mem_we` high for one cycle, `mem_wdata` equal to the word) only in write mode (mode 1).
- R4: Opcode 1000 loads: `clk_sel` from bit 11, `div_code` from bits 10:8, `tog_ext` from bit 4, `dma_mode` from bit 2, `pre_en` from bit 1 and `fill_pol` from bit 0. `wide_ext` comes from bit 3 and reads 0 whenever bit 4 is set.
- R5: Opcode 0111 loads `dma_words` from bits 8:0. Opcode 0110 loads `pre_len` from bits 11:0. Opcode 0100 loads `fmt_lifo` from bit 1 and `fmt_lsb` from bit 0.
- R6: Opcodes 1000, 0111, 0110 and 0100 take effect only in static mode; in any other mode the configuration outputs keep their values.
- R7: Opcode 0000 with bits 2:0 = 000 enters write mode from static or send-complete (mode 3) and resets the write address to 0. With bits 2:0 = 001 it enters send mode (mode 2) from write or send-complete; from static it is ignored.
- R8: Each stored word is written at the current address, which then advances by one and saturates at 319. The stored word count saturates at 320.
- R9: On entry to write mode `dreq_n` goes low if `dma_mode` is set and opcode-0000 bit 3 (mask) is clear; otherwise it stays high. It returns high once `dma_words`+1 words have been stored.
- R10: Entering send mode pulses `send_start` for one cycle, drives `busy_n` low and presents the stored word count on `send_words`. While sending, every command except stop is ignored. A `send_done` pulse moves the block to mode 3, raises `busy_n` and drives `intr_n` low.
- R11: Opcode 0010 (repeat) is accepted only in mode 3, where it restarts the send with the same word count; in other modes it is ignored.
- R12: Opcode 0011 in write mode sets `send_fill`, sets the word count to bits 8:0 plus one (capped at 320) and raises `dreq_n`.
- R13: Opcode 1111 is accepted in every mode. It returns to static and raises `busy_n`, `intr_n` and `dreq_n`. It clears the word count and `send_fill`, and keeps all configuration outputs.
- R14: Any accepted command clears a pending interrupt (`intr_n` back high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe, word taken on its rising edge |
| cs_n | input | 1 | Active-low chip select |
| cd | input | 1 | 1 = command, 0 = data |
| dack_n | input | 1 | Active-low DMA acknowledge |
| din | input | 16 | Write data bus |
| send_done | input | 1 | Send engine reports the line finished |
| mem_we | output | 1 | Line memory write enable |
| mem_addr | output | 9 | Line memory write address |
| mem_wdata | output | 16 | Line memory write data |
| mode | output | 2 | 0 static, 1 write, 2 send, 3 send complete |
| busy_n | output | 1 | Low while sending |
| intr_n | output | 1 | Low when a send has completed |
| dreq_n | output | 1 | Active-low DMA request |
| send_start | output | 1 | One-cycle start pulse for the send engine |
| send_words | output | 9 | Stored word count for the send |
| send_fill | output | 1 | Line consists of fixed data only |
| clk_sel | output | 1 | 1 = free-running system clock source |
| div_code | output | 3 | Clock divide code |
| tog_ext | output | 1 | Toggle cascade flag |
| wide_ext | output | 1 | 32-bit cascade flag |
| dma_mode | output | 1 | DMA request mode flag |
| pre_en | output | 1 | Fixed preamble enable |
| fill_pol | output | 1 | Fixed data polarity |
| fmt_lifo | output | 1 | 1 = LIFO order |
| fmt_lsb | output | 1 | 1 = LSB first |
| pre_len | output | 12 | Preamble length field |
| dma_words | output | 9 | DMA word count field |

## Verification
A wrong mode state shows at the `mode` port in the cycle after the offending write. It also shows through a write that should have been ignored, or a valid one that was refused: a configuration field that changes, a `send_start` that fires or fails to fire, or a `mem_we` pulse outside write mode. A bad address or count register shows first as a wrong `mem_addr` on the next stored word, and at the latest as a wrong `send_words` when the send starts. A wrong DMA comparison shows as `dreq_n` rising one word early or late. The directed sequences therefore check each of these ports in the single cycle after every write.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

  typedef enum logic [1:0] {
    M_STATIC = 2'd0,
    M_WRITE  = 2'd1,
    M_SEND   = 2'd2,
    M_DONE   = 2'd3
  } mode_t;

  localparam logic [3:0] OP_INIT   = 4'b1000;
  localparam logic [3:0] OP_DMACNT = 4'b0111;
  localparam logic [3:0] OP_PRELEN = 4'b0110;
  localparam logic [3:0] OP_FMT    = 4'b0100;
  localparam logic [3:0] OP_MODE   = 4'b0000;
  localparam logic [3:0] OP_FILL   = 4'b0011;
  localparam logic [3:0] OP_REPEAT = 4'b0010;
  localparam logic [3:0] OP_STOP   = 4'b1111;

  typedef struct packed {
    logic       clk_sel;
    logic [2:0] div;
    logic       tog;
    logic       wide;
    logic       dma;
    logic       pre_en;
    logic       pol;
  } init_t;

endpackage

// File: rtl/lcc_bus_decode.sv
module lcc_bus_decode #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              cs_n,
  input  logic              cd,
  input  logic              dack_n,
  input  logic [DATA_W-1:0] din,
  output logic              cmd_stb,
  output logic              dat_stb,
  output logic [DATA_W-1:0] word
);

  logic wr_q;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= wr_n;
  end

  always_comb begin
    rise    = wr_n & ~wr_q;
    cmd_stb = rise & ~cs_n & cd & dack_n;
    dat_stb = rise & (~dack_n | (~cs_n & ~cd));
    word    = din;
  end

endmodule

// File: rtl/lcc_cfg_regs.sv
module lcc_cfg_regs
  import lcc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 12,
  parameter int DCNT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] word,
  output init_t             init_q,
  output logic [1:0]        fmt_q,
  output logic [LEN_W-1:0]  pre_len_q,
  output logic [DCNT_W-1:0] dma_words_q
);

  init_t             init_n;
  logic [1:0]        fmt_n;
  logic [LEN_W-1:0]  pre_len_n;
  logic [DCNT_W-1:0] dma_words_n;
  logic [3:0]        op;

  always_comb begin
    op          = word[DATA_W-1 -: 4];
    init_n      = init_q;
    fmt_n       = fmt_q;
    pre_len_n   = pre_len_q;
    dma_words_n = dma_words_q;
    if (cfg_we) begin
      unique case (op)
        OP_INIT: begin
          init_n.clk_sel = word[11];
          init_n.div     = word[10:8];
          init_n.tog     = word[4];
          init_n.wide    = word[3];
          init_n.dma     = word[2];
          init_n.pre_en  = word[1];
          init_n.pol     = word[0];
        end
        OP_DMACNT: dma_words_n = word[DCNT_W-1:0];
        OP_PRELEN: pre_len_n   = word[LEN_W-1:0];
        OP_FMT:    fmt_n       = word[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q      <= '0;
      fmt_q       <= '0;
      pre_len_q   <= '0;
      dma_words_q <= '0;
    end else if (cfg_we) begin
      init_q      <= init_n;
      fmt_q       <= fmt_n;
      pre_len_q   <= pre_len_n;
      dma_words_q <= dma_words_n;
    end
  end

endmodule

// File: rtl/lcc_mode_fsm.sv
module lcc_mode_fsm
  import lcc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic [DATA_W-1:0] word,
  input  logic              send_done,
  output mode_t             mode_q,
  output logic              busy_n_q,
  output logic              intr_n_q,
  output logic              start_q,
  output logic              fill_q,
  output logic              cfg_we,
  output logic              go_write,
  output logic              fill_go,
  output logic              stop_go
);

  mode_t      mode_n;
  logic       busy_n_n, intr_n_n, start_n, fill_n;
  logic       go_send, rep_go, accepted;
  logic [3:0] op;

  always_comb begin
    op       = word[DATA_W-1 -: 4];
    stop_go  = cmd_stb && (op == OP_STOP);
    go_write = cmd_stb && (op == OP_MODE) && (word[2:0] == 3'b000) &&
               ((mode_q == M_STATIC) || (mode_q == M_DONE));
    go_send  = cmd_stb && (op == OP_MODE) && (word[2:0] == 3'b001) &&
               ((mode_q == M_WRITE) || (mode_q == M_DONE));
    rep_go   = cmd_stb && (op == OP_REPEAT) && (mode_q == M_DONE);
    fill_go  = cmd_stb && (op == OP_FILL) && (mode_q == M_WRITE);
    cfg_we   = cmd_stb && (mode_q == M_STATIC) &&
               ((op == OP_INIT) || (op == OP_DMACNT) ||
                (op == OP_PRELEN) || (op == OP_FMT));
    accepted = stop_go | go_write | go_send | rep_go | fill_go | cfg_we;

    mode_n   = mode_q;
    busy_n_n = busy_n_q;
    intr_n_n = intr_n_q;
    fill_n   = fill_q;
    start_n  = 1'b0;
    if (accepted) intr_n_n = 1'b1;
    if (stop_go) begin
      mode_n   = M_STATIC;
      busy_n_n = 1'b1;
      fill_n   = 1'b0;
    end else if (go_write) begin
      mode_n = M_WRITE;
      fill_n = 1'b0;
    end else if (go_send || rep_go) begin
      mode_n   = M_SEND;
      busy_n_n = 1'b0;
      start_n  = 1'b1;
    end else if (fill_go) begin
      fill_n = 1'b1;
    end else if ((mode_q == M_SEND) && send_done) begin
      mode_n   = M_DONE;
      busy_n_n = 1'b1;
      intr_n_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_STATIC;
      busy_n_q <= 1'b1;
      intr_n_q <= 1'b1;
      start_q  <= 1'b0;
      fill_q   <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      busy_n_q <= busy_n_n;
      intr_n_q <= intr_n_n;
      start_q  <= start_n;
      fill_q   <= fill_n;
    end
  end

endmodule

// File: rtl/lcc_wr_addr.sv
module lcc_wr_addr
  import lcc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 320,
  parameter int DCNT_W = 9,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int CMP_W  = ((CNT_W > DCNT_W) ? CNT_W : DCNT_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode_q,
  input  logic              dat_stb,
  input  logic              go_write,
  input  logic              fill_go,
  input  logic              stop_go,
  input  logic              dma_mode,
  input  logic [DCNT_W-1:0] dma_words,
  input  logic [DATA_W-1:0] word,
  output logic              mem_we_q,
  output logic [ADDR_W-1:0] mem_addr_q,
  output logic [DATA_W-1:0] mem_wdata_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              dreq_n_q
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic [CNT_W-1:0]  cnt_n;
  logic              dreq_n_n;
  logic              store;
  logic [CMP_W-1:0]  dma_target;
  logic [CMP_W-1:0]  fill_words;

  always_comb begin
    store      = dat_stb && (mode_q == M_WRITE);
    dma_target = CMP_W'(dma_words) + CMP_W'(1);
    fill_words = CMP_W'(word[DCNT_W-1:0]) + CMP_W'(1);
    ptr_n      = ptr_q;
    cnt_n      = cnt_q;
    dreq_n_n   = dreq_n_q;
    if (stop_go) begin
      ptr_n    = '0;
      cnt_n    = '0;
      dreq_n_n = 1'b1;
    end else if (go_write) begin
      ptr_n    = '0;
      cnt_n    = '0;
      dreq_n_n = ~(dma_mode & ~word[3]);
    end else if (fill_go) begin
      cnt_n    = (fill_words > CMP_W'(DEPTH)) ? FULL_CNT : CNT_W'(fill_words);
      dreq_n_n = 1'b1;
    end else if (store) begin
      if (ptr_q != LAST_ADDR) ptr_n = ptr_q + 1'b1;
      if (cnt_q != FULL_CNT)  cnt_n = cnt_q + 1'b1;
      if (CMP_W'(cnt_n) == dma_target) dreq_n_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      cnt_q    <= '0;
      dreq_n_q <= 1'b1;
      mem_we_q <= 1'b0;
    end else begin
      ptr_q    <= ptr_n;
      cnt_q    <= cnt_n;
      dreq_n_q <= dreq_n_n;
      mem_we_q <= store;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
    end else if (store) begin
      mem_addr_q  <= ptr_q;
      mem_wdata_q <= word;
    end
  end

endmodule

// File: rtl/line_cmd_ctrl.sv
module line_cmd_ctrl
  import lcc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 320,
  parameter int LEN_W  = 12,
  parameter int DCNT_W = 9,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              cs_n,
  input  logic              cd,
  input  logic              dack_n,
  input  logic [DATA_W-1:0] din,
  input  logic              send_done,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [1:0]        mode,
  output logic              busy_n,
  output logic              intr_n,
  output logic              dreq_n,
  output logic              send_start,
  output logic [CNT_W-1:0]  send_words,
  output logic              send_fill,
  output logic              clk_sel,
  output logic [2:0]        div_code,
  output logic              tog_ext,
  output logic              wide_ext,
  output logic              dma_mode,
  output logic              pre_en,
  output logic              fill_pol,
  output logic              fmt_lifo,
  output logic              fmt_lsb,
  output logic [LEN_W-1:0]  pre_len,
  output logic [DCNT_W-1:0] dma_words
);

  logic              cmd_stb, dat_stb;
  logic [DATA_W-1:0] word;
  logic              cfg_we, go_write, fill_go, stop_go;
  mode_t             mode_q;
  init_t             init_q;
  logic [1:0]        fmt_q;

  lcc_bus_decode #(.DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cs_n(cs_n), .cd(cd),
    .dack_n(dack_n), .din(din), .cmd_stb(cmd_stb), .dat_stb(dat_stb),
    .word(word)
  );

  lcc_mode_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .word(word),
    .send_done(send_done), .mode_q(mode_q), .busy_n_q(busy_n),
    .intr_n_q(intr_n), .start_q(send_start), .fill_q(send_fill),
    .cfg_we(cfg_we), .go_write(go_write), .fill_go(fill_go),
    .stop_go(stop_go)
  );

  lcc_cfg_regs #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DCNT_W(DCNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .word(word),
    .init_q(init_q), .fmt_q(fmt_q), .pre_len_q(pre_len),
    .dma_words_q(dma_words)
  );

  lcc_wr_addr #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DCNT_W(DCNT_W)) u_wa (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .dat_stb(dat_stb),
    .go_write(go_write), .fill_go(fill_go), .stop_go(stop_go),
    .dma_mode(init_q.dma), .dma_words(dma_words), .word(word),
    .mem_we_q(mem_we), .mem_addr_q(mem_addr), .mem_wdata_q(mem_wdata),
    .cnt_q(send_words), .dreq_n_q(dreq_n)
  );

  always_comb begin
    mode     = mode_q;
    clk_sel  = init_q.clk_sel;
    div_code = init_q.div;
    tog_ext  = init_q.tog;
    wide_ext = init_q.wide & ~init_q.tog;
    dma_mode = init_q.dma;
    pre_en   = init_q.pre_en;
    fill_pol = init_q.pol;
    fmt_lifo = fmt_q[1];
    fmt_lsb  = fmt_q[0];
  end

endmodule

// File: rtl/lcc_checker.sv
module lcc_checker #(
  parameter int DEPTH  = 320,
  parameter int ADDR_W = 9,
  parameter int LEN_W  = 12,
  parameter int DCNT_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mode,
  input logic              busy_n,
  input logic              intr_n,
  input logic              dreq_n,
  input logic              send_start,
  input logic              fmt_lifo,
  input logic              fmt_lsb,
  input logic [LEN_W-1:0]  pre_len,
  input logic [DCNT_W-1:0] dma_words,
  input logic              tog_ext,
  input logic              wide_ext
);

  // R3: memory writes only happen in write mode
  p_we_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mode == 2'd1));

  // R8: the address never leaves the line
  p_addr_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr <= ADDR_W'(DEPTH - 1)));

  // R10: start is a single-cycle pulse followed by busy
  p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    send_start |=> !send_start);
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    send_start |-> (!busy_n && mode == 2'd2));

  // R10: interrupt only rises out of send mode
  p_intr_from_send_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intr_n) |-> ($past(mode) == 2'd2 && mode == 2'd3));

  // R6: configuration holds outside static mode
  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |=> ($stable(fmt_lifo) && $stable(fmt_lsb) &&
                        $stable(pre_len) && $stable(dma_words)));

  // R13: static mode has no request and no busy
  p_static_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (dreq_n && busy_n));

  // R4: the two cascade flags are never both reported
  p_ext_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tog_ext && wide_ext));

endmodule

bind line_cmd_ctrl lcc_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DCNT_W(DCNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
  .mode(mode), .busy_n(busy_n), .intr_n(intr_n), .dreq_n(dreq_n),
  .send_start(send_start), .fmt_lifo(fmt_lifo), .fmt_lsb(fmt_lsb),
  .pre_len(pre_len), .dma_words(dma_words), .tog_ext(tog_ext),
  .wide_ext(wide_ext)
);

// File: tb/line_cmd_ctrl_test.sv
`timescale 1ns/1ps
module line_cmd_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n, wr_n, cs_n, cd, dack_n, send_done;
  logic [15:0] din;
  logic        mem_we, busy_n, intr_n, dreq_n, send_start, send_fill;
  logic [8:0]  mem_addr, send_words, dma_words;
  logic [15:0] mem_wdata;
  logic [1:0]  mode;
  logic        clk_sel, tog_ext, wide_ext, dma_mode, pre_en, fill_pol;
  logic        fmt_lifo, fmt_lsb;
  logic [2:0]  div_code;
  logic [11:0] pre_len;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  line_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cs_n(cs_n), .cd(cd),
    .dack_n(dack_n), .din(din), .send_done(send_done),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mode(mode), .busy_n(busy_n), .intr_n(intr_n), .dreq_n(dreq_n),
    .send_start(send_start), .send_words(send_words),
    .send_fill(send_fill), .clk_sel(clk_sel), .div_code(div_code),
    .tog_ext(tog_ext), .wide_ext(wide_ext), .dma_mode(dma_mode),
    .pre_en(pre_en), .fill_pol(fill_pol), .fmt_lifo(fmt_lifo),
    .fmt_lsb(fmt_lsb), .pre_len(pre_len), .dma_words(dma_words)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic c_n, input logic c_d, input logic d_n,
                        input logic [15:0] w);
    @(negedge clk);
    cs_n = c_n; cd = c_d; dack_n = d_n; din = w; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; cd = 1'b0; dack_n = 1'b1;
  endtask

  task automatic host_cmd(input logic [15:0] w); bus_wr(1'b0, 1'b1, 1'b1, w); endtask
  task automatic host_dat(input logic [15:0] w); bus_wr(1'b0, 1'b0, 1'b1, w); endtask
  task automatic dma_dat(input logic [15:0] w);  bus_wr(1'b1, 1'b1, 1'b0, w); endtask

  task automatic finish_send();
    @(negedge clk); send_done = 1'b1;
    @(negedge clk); send_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0);
    chk("R1 flags", {busy_n, intr_n, dreq_n, mem_we, send_start}, 5'b11100);
    chk("R1 cfg", {clk_sel, div_code, tog_ext, wide_ext, dma_mode, pre_en,
                   fill_pol, fmt_lifo, fmt_lsb, pre_len, dma_words}, 0);
  endtask

  task automatic t_config();
    bus_wr(1'b1, 1'b1, 1'b1, 16'h4003);
    chk("R2 deselected", {fmt_lifo, fmt_lsb}, 0);
    host_cmd(16'h8B1F);
    chk("R4 init fields", {clk_sel, div_code, tog_ext, wide_ext, dma_mode,
                           pre_en, fill_pol}, 9'b1_011_10111);
    host_cmd(16'h8008);
    chk("R4 wide alone", {clk_sel, tog_ext, wide_ext, dma_mode}, 4'b0010);
    host_cmd(16'h7005);
    chk("R5 dma count", dma_words, 5);
    host_cmd(16'h6ABC);
    chk("R5 preamble", pre_len, 12'hABC);
    host_cmd(16'h4002);
    chk("R5 format", {fmt_lifo, fmt_lsb}, 2'b10);
    @(negedge clk);
    cs_n = 1'b0; cd = 1'b1; din = 16'h4001; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 held low", {fmt_lifo, fmt_lsb}, 2'b10);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; cd = 1'b0;
    chk("R2 rising edge", {fmt_lifo, fmt_lsb}, 2'b01);
    host_cmd(16'h0001);
    chk("R7 send from static", {mode, send_start}, 3'b000);
  endtask

  task automatic t_dma_line();
    host_cmd(16'h8004);
    host_cmd(16'h7002);
    host_cmd(16'h0000);
    chk("R7 enter write", mode, 1);
    chk("R9 request low", dreq_n, 0);
    dma_dat(16'hA001);
    chk("R3 dma store", {mem_we, mem_addr, mem_wdata}, {1'b1, 9'd0, 16'hA001});
    @(negedge clk);
    chk("R3 we pulse", mem_we, 0);
    host_dat(16'hA002);
    chk("R8 address", mem_addr, 1);
    chk("R9 still low", dreq_n, 0);
    host_cmd(16'h4003);
    chk("R6 format frozen", {fmt_lifo, fmt_lsb}, 2'b01);
    dma_dat(16'hA003);
    chk("R9 request done", {mem_addr, dreq_n}, {9'd2, 1'b1});
    host_cmd(16'h2000);
    chk("R11 repeat in write", {mode, send_start}, {2'd1, 1'b0});
    host_cmd(16'h0001);
    chk("R10 start", {mode, busy_n, send_start, send_words}, {2'd2, 1'b0, 1'b1, 9'd3});
    @(negedge clk);
    chk("R10 start pulse", send_start, 0);
    host_cmd(16'h0000);
    chk("R10 mode cmd ignored", mode, 2);
    host_dat(16'h5555);
    chk("R3 no store in send", mem_we, 0);
    finish_send();
    chk("R10 done", {mode, busy_n, intr_n}, {2'd3, 1'b1, 1'b0});
    host_cmd(16'h2000);
    chk("R11 repeat", {mode, send_start, send_words}, {2'd2, 1'b1, 9'd3});
    chk("R14 repeat clears irq", intr_n, 1);
    finish_send();
    chk("R10 done again", intr_n, 0);
    host_cmd(16'h0000);
    chk("R14 write clears irq", {mode, intr_n, dreq_n}, {2'd1, 1'b1, 1'b0});
    host_dat(16'h1234);
    chk("R7 address reset", {mem_addr, mem_wdata}, {9'd0, 16'h1234});
    host_cmd(16'hF000);
    chk("R13 stop", {mode, busy_n, intr_n, dreq_n, send_words},
        {2'd0, 1'b1, 1'b1, 1'b1, 9'd0});
    chk("R13 config kept", {dma_mode, dma_words, pre_len, fmt_lsb},
        {1'b1, 9'd2, 12'hABC, 1'b1});
  endtask

  task automatic t_mask_fill();
    host_cmd(16'h0008);
    chk("R9 masked", {mode, dreq_n}, {2'd1, 1'b1});
    host_cmd(16'h3004);
    chk("R12 fill", {send_fill, send_words}, {1'b1, 9'd5});
    host_cmd(16'h0001);
    chk("R12 fill send", {send_start, send_words}, {1'b1, 9'd5});
    host_cmd(16'hF000);
    chk("R13 stop in send", {mode, busy_n, send_fill}, {2'd0, 1'b1, 1'b0});
    host_cmd(16'h0008);
    host_cmd(16'h31FF);
    chk("R12 fill cap", send_words, 320);
    host_cmd(16'hF000);
  endtask

  task automatic t_saturate();
    host_cmd(16'h8000);
    host_cmd(16'h0000);
    chk("R9 no dma mode", {mode, dreq_n}, {2'd1, 1'b1});
    for (int i = 0; i < 321; i++) begin
      host_dat(16'(i));
      if (i == 319) chk("R8 last address", mem_addr, 319);
      if (i == 320) chk("R8 address saturates", {mem_addr, mem_wdata}, {9'd319, 16'd320});
    end
    host_cmd(16'h0001);
    chk("R8 count saturates", send_words, 320);
    finish_send();
    host_cmd(16'hF000);
    chk("R13 final stop", mode, 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_n = 1'b1; cs_n = 1'b1; cd = 1'b0; dack_n = 1'b1;
    din = '0; send_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_dma_line();
    t_mask_fill();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule